// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block serves a bank of general-purpose pins (32 by default) through a word-addressed register port. Each pin can be an input or an output. An output pin is reduced to an output-enable and an output-data signal for the pad. Every pad input passes through a two-flop synchronizer. The synchronized value feeds the value register and the interrupt detector.

Each pin has a trigger mode, set by three type bits. The detector records hits in a sticky status register, which software clears by writing ones. The bank raises one interrupt line whenever any pin has both a pending status bit and an enable bit. Status bits are recorded even while the pin's enable bit is clear, so a masked event is not lost. The register port is a plain one-cycle write strobe with combinational read data. It has no handshake and no back-pressure: each write takes effect at the clock edge where it is presented.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 (all pins are inputs) and `irq` is 0.
- R2: The direction register is at word 1, where bit value 1 means output. Its value appears on `pad_oe` the cycle after the write. A write to word 0 loads the output latch, which appears on `pad_out` the cycle after the write.
- R3: A read of word 0 returns `pad_in` as it was two clock edges earlier, even for pins set as outputs. A pad change is not visible after only one edge.
- R4: Word 2 is read-only and returns the output latch. A write to word 2 changes nothing.
- R5: Trigger mode uses the bits {type2 (word 7), type1 (word 6), type0 (word 5)}. Mode 001 sets the pin's status bit on a rising edge of the synchronized input, and not on a falling edge.
- R6: Mode 000 sets status on a falling edge only.
- R7: Mode 101 (type1 = 0, type2 = 1, type0 = 1) sets status on either edge.
- R8: Mode 011 sets status in every cycle the input is high, and mode 010 in every cycle it is low. Clearing status while the level persists leaves it set.
- R9: Writing to the status register (word 8) clears each bit written as 1. Bits written as 0 are left unchanged. No other write lowers a status bit.
- R10: `irq` is high exactly when some pin has both its status bit and its enable bit (word 4) set. Status is recorded regardless of the enable bit.
- R11: When a detected event and a clearing write hit the same pin in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address for a read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output data |
| irq | output | 1 | Combined bank interrupt |

## Verification
The sticky status register has two writers: the detector, which sets bits, and the software clear, which lowers them. These two can act on the same bit in the same clock. The bench provokes this by timing a status clear write so that it commits at the very edge where a synchronized rising edge reaches the detector. The check passes only if that pin's status bit still reads 1 afterwards. A separate level-mode check clears a bit while its level persists and expects the bit to come back.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  // Word addresses of the register port
  localparam int unsigned A_VALUE = 0;
  localparam int unsigned A_DIR   = 1;
  localparam int unsigned A_LATCH = 2;
  localparam int unsigned A_IEN   = 4;
  localparam int unsigned A_TRIG0 = 5;
  localparam int unsigned A_TRIG1 = 6;
  localparam int unsigned A_TRIG2 = 7;
  localparam int unsigned A_STAT  = 8;

  // Detection for one pin. Mode bits: {t2, t1, t0}.
  function automatic logic trig_hit(input logic t2, input logic t1, input logic t0,
                                    input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (t1)             return t0 ? cur : ~cur;
    else if (t2 && t0)  return rise | fall;
    else if (t0)        return rise;
    else                return fall;
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic [WIDTH-1:0]  stat_q,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  trig0_q,
  output logic [WIDTH-1:0]  trig1_q,
  output logic [WIDTH-1:0]  trig2_q,
  output logic [WIDTH-1:0]  stat_clr
);
  localparam logic [ADDR_W-1:0] W_VALUE = ADDR_W'(A_VALUE);
  localparam logic [ADDR_W-1:0] W_DIR   = ADDR_W'(A_DIR);
  localparam logic [ADDR_W-1:0] W_LATCH = ADDR_W'(A_LATCH);
  localparam logic [ADDR_W-1:0] W_IEN   = ADDR_W'(A_IEN);
  localparam logic [ADDR_W-1:0] W_TRIG0 = ADDR_W'(A_TRIG0);
  localparam logic [ADDR_W-1:0] W_TRIG1 = ADDR_W'(A_TRIG1);
  localparam logic [ADDR_W-1:0] W_TRIG2 = ADDR_W'(A_TRIG2);
  localparam logic [ADDR_W-1:0] W_STAT  = ADDR_W'(A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      trig0_q <= '0;
      trig1_q <= '0;
      trig2_q <= '0;
    end else if (wr) begin
      case (addr)
        W_VALUE: latch_q <= wdata;
        W_DIR:   dir_q   <= wdata;
        W_IEN:   ien_q   <= wdata;
        W_TRIG0: trig0_q <= wdata;
        W_TRIG1: trig1_q <= wdata;
        W_TRIG2: trig2_q <= wdata;
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr && addr == W_STAT) ? wdata : '0;

  always_comb begin
    case (addr)
      W_VALUE: rdata = pin_sync;
      W_DIR:   rdata = dir_q;
      W_LATCH: rdata = latch_q;
      W_IEN:   rdata = ien_q;
      W_TRIG0: rdata = trig0_q;
      W_TRIG1: rdata = trig1_q;
      W_TRIG2: rdata = trig2_q;
      W_STAT:  rdata = stat_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect
  import gpb_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] trig0,
  input  logic [WIDTH-1:0] trig1,
  input  logic [WIDTH-1:0] trig2,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] stat_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      assign hit[i] = trig_hit(trig2[i], trig1[i], trig0[i], pin_sync[i], prev_q[i]);
    end
  endgenerate

  // A hit in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_sync;
      stat_q <= (stat_q & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic              irq
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] latch_q, dir_q, ien_q;
  logic [WIDTH-1:0] trig0_q, trig1_q, trig2_q;
  logic [WIDTH-1:0] stat_q, stat_clr;

  gpb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpb_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pin_sync(pin_sync), .stat_q(stat_q),
    .latch_q(latch_q), .dir_q(dir_q), .ien_q(ien_q),
    .trig0_q(trig0_q), .trig1_q(trig1_q), .trig2_q(trig2_q),
    .stat_clr(stat_clr)
  );

  gpb_detect #(.WIDTH(WIDTH)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
    .trig0(trig0_q), .trig1(trig1_q), .trig2(trig2_q),
    .clr(stat_clr), .stat_q(stat_q)
  );

  assign pad_oe  = dir_q;
  assign pad_out = latch_q;
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic              irq,
  input logic [WIDTH-1:0]  stat,
  input logic [WIDTH-1:0]  ien
);
  logic wr_dir, wr_val, wr_stat;
  assign wr_dir  = reg_wr && reg_addr == ADDR_W'(A_DIR);
  assign wr_val  = reg_wr && reg_addr == ADDR_W'(A_VALUE);
  assign wr_stat = reg_wr && reg_addr == ADDR_W'(A_STAT);

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pad_oe == $past(reg_wdata)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_val |=> $stable(pad_out)); // R4
  AST_STAT_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ($past(stat) & ~stat) == '0); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R10
endmodule

bind gpio_irq_bank gpb_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
  .stat(stat_q), .ien(ien_q)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {mode[2:0], pin[4:0], start, final, expected status}
  localparam logic [10:0] VEC [NV] = '{
    {3'b001, 5'd3,  1'b0, 1'b1, 1'b1},  // R5 rise
    {3'b001, 5'd3,  1'b1, 1'b0, 1'b0},  // R5 fall ignored
    {3'b000, 5'd7,  1'b1, 1'b0, 1'b1},  // R6 fall
    {3'b000, 5'd7,  1'b0, 1'b1, 1'b0},  // R6 rise ignored
    {3'b101, 5'd12, 1'b0, 1'b1, 1'b1},  // R7 both, rise
    {3'b101, 5'd12, 1'b1, 1'b0, 1'b1},  // R7 both, fall
    {3'b011, 5'd20, 1'b0, 1'b1, 1'b1},  // R8 high level
    {3'b010, 5'd31, 1'b1, 1'b0, 1'b1},  // R8 low level
    {3'b011, 5'd0,  1'b0, 1'b0, 1'b0},  // R8 high level absent
    {3'b010, 5'd5,  1'b1, 1'b1, 1'b0}   // R8 low level absent
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), r);
      chk(r == 0, "R1 register reset", r, 0);
    end
    chk(pad_oe == 0, "R1 pad_oe reset", pad_oe, 0);
    chk({31'b0, irq} == 0, "R1 irq reset", {31'b0, irq}, 0);

    // Vector table for trigger modes (R5..R8)
    foreach (VEC[v]) begin
      logic [2:0]  md;
      logic [4:0]  pin;
      logic [31:0] bitm;
      md = VEC[v][10:8]; pin = VEC[v][7:3];
      bitm = 32'h1 << pin;
      wr(4'd5, md[0] ? bitm : 0);
      wr(4'd6, md[1] ? bitm : 0);
      wr(4'd7, md[2] ? bitm : 0);
      pad_in = VEC[v][2] ? bitm : 0;
      repeat (4) @(negedge clk);
      wr(4'd8, 32'hFFFF_FFFF);
      @(negedge clk);
      pad_in = VEC[v][1] ? bitm : 0;
      repeat (3) @(negedge clk);
      rd(4'd8, r);
      chk(((r >> pin) & 1) == 32'(VEC[v][0]), $sformatf("R5-8 vector %0d", v),
          (r >> pin) & 1, 32'(VEC[v][0]));
    end
    wr(4'd5, 0); wr(4'd6, 0); wr(4'd7, 0);
    pad_in = 0;
    repeat (4) @(negedge clk);
    wr(4'd8, 32'hFFFF_FFFF);

    // R2 direction and latch
    wr(4'd1, 32'hF0F0_0000);
    chk(pad_oe == 32'hF0F0_0000, "R2 pad_oe", pad_oe, 32'hF0F0_0000);
    wr(4'd0, 32'h1234_5678);
    chk(pad_out == 32'h1234_5678, "R2 pad_out", pad_out, 32'h1234_5678);

    // R4 latch readback, read-only
    rd(4'd2, r);
    chk(r == 32'h1234_5678, "R4 latch readback", r, 32'h1234_5678);
    wr(4'd2, 32'h0000_FFFF);
    rd(4'd2, r);
    chk(r == 32'h1234_5678, "R4 write to latch readback ignored", r, 32'h1234_5678);
    chk(pad_out == 32'h1234_5678, "R4 pad_out unchanged", pad_out, 32'h1234_5678);

    // R3 synchronized value, two-edge latency, output pins too
    pad_in = 32'hA5A5_0001;
    @(negedge clk);
    rd(4'd0, r);
    chk(r == 0, "R3 not visible after one edge", r, 0);
    @(negedge clk);
    rd(4'd0, r);
    chk(r == 32'hA5A5_0001, "R3 value after two edges", r, 32'hA5A5_0001);
    pad_in = 0;
    repeat (3) @(negedge clk);
    wr(4'd8, 32'hFFFF_FFFF);

    // R9 write-one-to-clear
    wr(4'd5, 32'h8);              // pin 3 rising
    pad_in = 32'h8;
    repeat (3) @(negedge clk);
    wr(4'd8, 32'h0);
    rd(4'd8, r);
    chk(r == 32'h8, "R9 zero write no effect", r, 32'h8);

    // R10 enable gating
    chk(irq == 1'b0, "R10 masked status no irq", {31'b0, irq}, 0);
    wr(4'd4, 32'h1);
    chk(irq == 1'b0, "R10 other pin enabled", {31'b0, irq}, 0);
    wr(4'd4, 32'h8);
    chk(irq == 1'b1, "R10 enabled status irq", {31'b0, irq}, 1);

    wr(4'd8, 32'h8);
    rd(4'd8, r);
    chk(r == 0, "R9 one write clears", r, 0);
    chk(irq == 1'b0, "R10 irq drops after clear", {31'b0, irq}, 0);

    // R11 clear and rising edge in same cycle
    pad_in = 0;
    repeat (3) @(negedge clk);
    wr(4'd8, 32'hFFFF_FFFF);
    pad_in = 32'h8;
    @(negedge clk);
    wr(4'd8, 32'h8);              // commits on the edge the hit arrives
    rd(4'd8, r);
    chk(r == 32'h8, "R11 set wins over clear", r, 32'h8);

    // R8 level re-sets after clear
    wr(4'd5, 32'h0010_0000);
    wr(4'd6, 32'h0010_0000);
    pad_in = 32'h0010_0000;
    repeat (3) @(negedge clk);
    wr(4'd8, 32'h0010_0000);
    @(negedge clk);
    rd(4'd8, r);
    chk((r & 32'h0010_0000) != 0, "R8 level persists after clear",
        r & 32'h0010_0000, 32'h0010_0000);

    finish_run();
  end
endmodule